// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

This block compares two byte arrays of equal length. The arrays sit in external memories that share one read address. A one-cycle `go` request starts a run. The engine then steps an index from zero up to the last element. At each index it raises a read strobe, reads one byte from each memory, forms the unsigned magnitude of their difference and adds that magnitude to a running total. When the index reaches the array length, the total is copied into a result register, and `sad` shows that register.

The memories must return data combinationally. The bytes for the presented address have to be valid in the same cycle as the strobe. The result register keeps its old value for the whole run, so a consumer can read `sad` at any time and always sees the last completed result. A new run always starts from a cleared total.

Top module: `sad_engine`

## Requirements
- R1: While reset is held and on its release, `sad` is 0, `mem_rd` is 0 and the engine is idle.
- R2: While idle with `go` low, `mem_rd` stays 0 and `sad` keeps its value.
- R3: A run raises `mem_rd` exactly DEPTH times, never in two consecutive cycles, with `mem_addr` taking the values 0, 1, …, DEPTH-1 in ascending order. The first strobe comes in the third cycle after the edge that samples `go`, and the strobes are spaced two cycles apart.
- R4: The completed result equals the sum over all indices of |A[i] − B[i]|, with both bytes taken as unsigned 8-bit values (0 to 255). The result is correct whichever operand is larger.
- R5: `sad` changes only at the end of a run. It holds its previous value from the `go` edge until the update.
- R6: `go` is ignored while a run is in progress. After the update the engine returns to idle. Each new run starts from a zero total and does not add to the previous result.
- R7: Identical arrays give 0. Arrays in which every pair differs by 255 give 255·DEPTH (65280 for DEPTH = 256).
- R8: The new result appears on `sad` on the (2·DEPTH+3)-th rising edge after the edge that samples `go`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled while idle |
| mem_rd | output | 1 | Read strobe shared by both memories |
| mem_addr | output | 8 | Shared element index for both memories |
| a_data | input | 8 | Byte read from array A at `mem_addr` |
| b_data | input | 8 | Byte read from array B at `mem_addr` |
| sad | output | 32 | Result of the last completed run |

## Verification
Each run type targets a different fault:
- Random byte arrays exercise the general sum.
- Arrays with A always 255 above B, and then B always 255 above A, show whether the magnitude is formed correctly when the raw difference is negative.
- Identical arrays run after a nonzero result show whether the total is cleared between runs. They also show whether the result register really updates to zero.
- A `go` pulse in the middle of a run shows whether a busy engine restarts.
- Holding `go` high across the end of a run shows that the engine goes back to idle and starts cleanly again.

The last result is checked one edge before and at the edge where it is due, which pins down the exact update cycle.

// File: rtl/sad_pkg.sv
package sad_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_INIT = 3'd1,
      ST_TEST = 3'd2,
      ST_ACC  = 3'd3,
      ST_DONE = 3'd4
   } sad_state_e;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
   import sad_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic idx_below,
   output logic idx_clr,
   output logic idx_inc,
   output logic sum_clr,
   output logic sum_ld,
   output logic res_ld,
   output logic mem_rd
);
   sad_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      idx_clr = 1'b0;
      idx_inc = 1'b0;
      sum_clr = 1'b0;
      sum_ld  = 1'b0;
      res_ld  = 1'b0;
      mem_rd  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (go) state_d = ST_INIT;
         ST_INIT: begin
            idx_clr = 1'b1;
            sum_clr = 1'b1;
            state_d = ST_TEST;
         end
         ST_TEST: state_d = idx_below ? ST_ACC : ST_DONE;
         ST_ACC: begin
            mem_rd  = 1'b1;
            sum_ld  = 1'b1;
            idx_inc = 1'b1;
            state_d = ST_TEST;
         end
         ST_DONE: begin
            res_ld  = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // R3
   rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   // R6
   busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));
   // R6
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_ld |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sad_index.sv
module sad_index #(
   parameter int DEPTH = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     inc,
   output logic [$clog2(DEPTH)-1:0] addr,
   output logic                     below
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int IDX_W  = ADDR_W + 1;
   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx_q <= '0;
      else if (clr) idx_q <= '0;
      else if (inc) idx_q <= idx_q + 1'b1;
   end

   assign below = (idx_q < LIMIT);
   assign addr  = idx_q[ADDR_W-1:0];

   // R3
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> below);
endmodule

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
   parameter int ELEM_W  = 8,
   parameter int VARIANT = 0
) (
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   output logic [ELEM_W-1:0] mag
);
   generate
      if (VARIANT == 0) begin : g_signed_sub
         logic signed [ELEM_W:0] delta;
         logic signed [ELEM_W:0] neg;
         assign delta = $signed({1'b0, a}) - $signed({1'b0, b});
         assign neg   = -delta;
         assign mag   = delta[ELEM_W] ? neg[ELEM_W-1:0] : delta[ELEM_W-1:0];
      end else begin : g_cmp_swap
         assign mag = (a >= b) ? (a - b) : (b - a);
      end
   endgenerate

   // R4
   always_comb begin
      mag_bound_chk: assert (mag <= ((a >= b) ? a : b));
   end
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
   parameter int ELEM_W = 8,
   parameter int SUM_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld,
   input  logic [ELEM_W-1:0] mag,
   output logic [SUM_W-1:0]  sum
);
   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum_q <= '0;
      else if (clr) sum_q <= '0;
      else if (ld)  sum_q <= sum_q + SUM_W'(mag);
   end

   assign sum = sum_q;

   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> (sum_q >= $past(sum_q)));
   // R6
   fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum_q == '0));
endmodule

// File: rtl/sad_engine.sv
module sad_engine #(
   parameter int DEPTH       = 256,
   parameter int ELEM_W      = 8,
   parameter int SUM_W       = 32,
   parameter int ABS_VARIANT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go,
   output logic                     mem_rd,
   output logic [$clog2(DEPTH)-1:0] mem_addr,
   input  logic [ELEM_W-1:0]        a_data,
   input  logic [ELEM_W-1:0]        b_data,
   output logic [SUM_W-1:0]         sad
);
   localparam int ADDR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sad_engine: DEPTH must be at least 2");
      end
      if (SUM_W < ELEM_W + ADDR_W) begin : g_bad_sum
         $error("sad_engine: SUM_W too narrow for worst-case total");
      end
      if (ABS_VARIANT != 0 && ABS_VARIANT != 1) begin : g_bad_var
         $error("sad_engine: ABS_VARIANT must be 0 or 1");
      end
   endgenerate

   logic idx_clr, idx_inc, sum_clr, sum_ld, res_ld, idx_below;
   logic [ELEM_W-1:0] mag;
   logic [SUM_W-1:0]  sum;
   logic [SUM_W-1:0]  res_q;

   sad_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .idx_below(idx_below),
      .idx_clr(idx_clr), .idx_inc(idx_inc), .sum_clr(sum_clr),
      .sum_ld(sum_ld), .res_ld(res_ld), .mem_rd(mem_rd)
   );

   sad_index #(.DEPTH(DEPTH)) u_index (
      .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
      .addr(mem_addr), .below(idx_below)
   );

   sad_absdiff #(.ELEM_W(ELEM_W), .VARIANT(ABS_VARIANT)) u_abs (
      .a(a_data), .b(b_data), .mag(mag)
   );

   sad_accum #(.ELEM_W(ELEM_W), .SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(sum_clr), .ld(sum_ld),
      .mag(mag), .sum(sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (res_ld) res_q <= sum;
   end

   assign sad = res_q;

   // R5
   sad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_ld |=> $stable(sad));
   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd, 2)) |->
         (mem_addr == ADDR_W'($past(mem_addr, 2) + 1'b1)));
   // R3
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !$past(mem_rd, 2)) |-> (mem_addr == '0));
endmodule

// File: tb/sad_engine_bench.sv
module sad_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 256;
   localparam int RUN_EDGES  = 2 * DEPTH + 3;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic        mem_rd;
   logic [7:0]  mem_addr;
   logic [7:0]  a_data, b_data;
   logic [31:0] sad;

   logic [7:0] mem_a [DEPTH];
   logic [7:0] mem_b [DEPTH];

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   int cycles = 0;

   // behavioural reference model state
   int m_st = 0;
   int m_i = 0;
   longint m_sum = 0;
   longint m_sad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign a_data = mem_a[mem_addr];
   assign b_data = mem_b[mem_addr];

   sad_engine u_sad_engine (
      .clk(clk), .rst_n(rst_n), .go(go), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .a_data(a_data), .b_data(b_data), .sad(sad)
   );

   function automatic longint absd(input int x, input int y);
      return (x > y) ? longint'(x - y) : longint'(y - x);
   endfunction

   function automatic longint golden();
      longint s = 0;
      for (int k = 0; k < DEPTH; k++) s += absd(int'(mem_a[k]), int'(mem_b[k]));
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model advances on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_i = 0; m_sum = 0; m_sad = 0;
      end else begin
         case (m_st)
            0: if (go) m_st = 1;
            1: begin m_sum = 0; m_i = 0; m_st = 2; end
            2: m_st = (m_i < DEPTH) ? 3 : 4;
            3: begin
               m_sum += absd(int'(mem_a[m_i]), int'(mem_b[m_i]));
               m_i++;
               m_st = 2;
            end
            default: begin m_sad = m_sum; m_st = 0; end
         endcase
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(mem_rd == (m_st == 3), "R3 strobe", mem_rd, m_st == 3);
         if (m_st == 3)
            check(mem_addr == m_i[7:0], "R3 address", mem_addr, m_i);
         check(sad == m_sad[31:0], "R5 result register", sad, m_sad);
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         summary();
      end
   end

   // one run with exact-cycle result checks; optional go pulse mid-run
   task automatic run(input longint exp, input bit mid_pulse, input string req);
      longint old_sad = sad;
      int strobes = 0;
      @(negedge clk); go = 1'b1;
      for (int k = 1; k <= RUN_EDGES; k++) begin
         @(negedge clk);
         go = (mid_pulse && k == 200);
         if (mem_rd) strobes++;
         if (k < RUN_EDGES && !mid_pulse && k > 1)
            ;
      end
      // now just after edge RUN_EDGES-1
      check(sad == old_sad[31:0], {req, " R8 not early"}, sad, old_sad);
      @(negedge clk);
      check(sad == exp[31:0], {req, " R8 due edge"}, sad, exp);
      check(sad == exp[31:0], req, sad, exp);
      check(strobes == DEPTH, "R3 strobe count", strobes, DEPTH);
      repeat (4) @(negedge clk);
      check(mem_rd == 1'b0, "R6 idle after run", mem_rd, 0);
   endtask

   initial begin
      for (int k = 0; k < DEPTH; k++) begin mem_a[k] = 8'd0; mem_b[k] = 8'd0; end
      repeat (3) @(negedge clk);
      // R1
      check(sad == 32'd0, "R1 sad in reset", sad, 0);
      check(mem_rd == 1'b0, "R1 strobe in reset", mem_rd, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sad == 32'd0, "R1 sad after reset", sad, 0);
      // R2: idle, no go
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check(mem_rd == 1'b0, "R2 idle strobe", mem_rd, 0);
      end
      check(sad == 32'd0, "R2 idle sad", sad, 0);

      // R4 random arrays
      for (int k = 0; k < DEPTH; k++) begin
         mem_a[k] = 8'($urandom);
         mem_b[k] = 8'($urandom);
      end
      run(golden(), 1'b0, "R4 random");

      // R7 identical arrays after nonzero result, R6 fresh start
      for (int k = 0; k < DEPTH; k++) mem_b[k] = mem_a[k];
      run(0, 1'b0, "R7 identical");

      // R7 max difference, A larger then B larger (R4 sign)
      for (int k = 0; k < DEPTH; k++) begin mem_a[k] = 8'd255; mem_b[k] = 8'd0; end
      run(255 * DEPTH, 1'b0, "R7 A above B");
      for (int k = 0; k < DEPTH; k++) begin mem_a[k] = 8'd0; mem_b[k] = 8'd255; end
      run(255 * DEPTH, 1'b0, "R4 B above A");

      // R6 go pulse mid-run is ignored, second identical run not accumulated
      for (int k = 0; k < DEPTH; k++) begin
         mem_a[k] = 8'(k);
         mem_b[k] = 8'(255 - k);
      end
      run(golden(), 1'b1, "R6 mid-run go");
      run(golden(), 1'b0, "R6 repeat run");

      // R6 go held high across the end of a run: model tracks restart
      @(negedge clk); go = 1'b1;
      repeat (RUN_EDGES + 40) @(negedge clk);
      check(sad == golden(), "R6 held go result", sad, golden());
      go = 1'b0;
      repeat (RUN_EDGES + 10) @(negedge clk);
      check(mem_rd == 1'b0, "R6 idle after held go", mem_rd, 0);
      summary();
   end
endmodule